// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Bridge

This block connects a peripheral that moves data sixteen bits at a time to a byte-addressed system memory port. A client issues a request with an offset, a byte count, a direction and a pass-through flag. The bridge then walks the transfer as a series of halfword beats on the memory side. Write data is taken from a byte-pair source stream. Read data is returned on a byte-pair sink stream.

The starting memory address is the request offset ORed with a channel base value; no adder is involved. In pass-through mode, address, length and data are used exactly as given, and an odd tail goes out as a one-byte beat. With pass-through off, the block enters its swapping mode. There it clears bit 0 of both the address and the length, and it exchanges the two bytes of every halfword in both directions. Swapped writes are also cut into bursts of at most `CHUNK_BYTES` bytes, and each burst is announced by a start-of-burst marker that carries the burst length.

Top module: `hsw_dma_bridge`

## Requirements
- R1: The address of the first memory beat equals `req_offset | base_addr` (bitwise OR, not a sum), with bit 0 cleared in swapping mode.
- R2: With `req_pass`=1, data passes unchanged in both directions, and the address and length are used as given, odd values included.
- R3: With `req_pass`=0, bit 0 of the start address and of the length are cleared before any beat, so every beat is at an even address and carries two bytes.
- R4: In swapping mode, on writes, `mem_wdata` = {`src_data[7:0]`, `src_data[15:8]`}.
- R5: In swapping mode, on reads, `snk_data` = {`mem_rdata[7:0]`, `mem_rdata[15:8]`}.
- R6: Swapped writes are split into bursts of min(remaining, `CHUNK_BYTES`) bytes. `mem_sob`=1 on the first beat of each burst, with `mem_blen` giving the burst length, and addresses run on contiguously from one burst to the next.
- R7: Reads, and writes in pass-through mode, form one burst. `mem_sob`=1 only on the first beat, with `mem_blen` equal to the whole length.
- R8: Each beat moves min(2, remaining) bytes. `mem_be`=2'b11 means two bytes and 2'b01 means only the low byte, which sits at `mem_addr` on `[7:0]`. The next beat's address is the previous address plus its byte count, and the address holds while a beat waits on `mem_ready`.
- R9: `done` is high for exactly the one cycle after the last halfword is accepted: at the memory port for writes, at the sink for reads. `busy` is low in that cycle.
- R10: A request whose length is zero after alignment produces no memory beat, and `done` rises in the cycle after it is accepted.
- R11: `busy` is high from the cycle after a nonzero request is accepted until its `done` cycle. A `req_valid` seen while `busy` is ignored.
- R12: After reset, `busy`, `done` and `mem_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_addr | input | ADDR_W | Channel base value ORed into the address |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_pass | input | 1 | 1: pass-through, 0: align and swap bytes |
| req_offset | input | ADDR_W | Request offset |
| req_len | input | LEN_W | Request length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_valid | input | 1 | Write data available |
| src_ready | output | 1 | Write data taken |
| src_data | input | 16 | Write data byte pair |
| snk_valid | output | 1 | Read data available |
| snk_ready | input | 1 | Read data taken |
| snk_data | output | 16 | Read data byte pair |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory beat accepted |
| mem_write | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_be | output | 2 | Beat byte enables |
| mem_wdata | output | 16 | Beat write data |
| mem_sob | output | 1 | First beat of a burst |
| mem_blen | output | LEN_W | Burst length in bytes, valid with mem_sob |
| mem_rvalid | input | 1 | Read response valid |
| mem_rready | output | 1 | Read response taken |
| mem_rdata | input | 16 | Read response data |

## Verification
The bench targets a base and offset whose set bits overlap, where a design that adds instead of ORing lands 16 bytes off. It uses an odd offset and odd length in swapping mode, where a missed alignment shows up as an odd address or a one-byte beat. A 150-byte swapped write must split 64/64/22; a design that ignores the chunk limit emits one burst marker, and one that chunks reads or pass-through writes emits extra markers. Other runs cover one-byte tails in pass-through mode, lengths that align down to zero (which must still finish with no beats), and a stray request during a transfer, which a design that fails to ignore it would turn into extra or wrong beats.

// File: rtl/hsw_dma_pkg.sv
package hsw_dma_pkg;

   localparam int unsigned BEAT_BYTES = 2;

   typedef enum logic [1:0] {
      XS_IDLE    = 2'd0,
      XS_WRITE   = 2'd1,
      XS_RD_CMD  = 2'd2,
      XS_RD_DATA = 2'd3
   } xfer_state_e;

endpackage

// File: rtl/hsw_req_align.sv
module hsw_req_align #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 16
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              pass_mode,
   output logic [ADDR_W-1:0] start_addr,
   output logic [LEN_W-1:0]  start_len
);

   // address is a merge of base and offset bits, never a sum
   always_comb begin
      start_addr = base_addr | offset;
      start_len  = len_in;
      if (!pass_mode) begin
         start_addr[0] = 1'b0;
         start_len[0]  = 1'b0;
      end
   end

endmodule

// File: rtl/hsw_lane_swap.sv
module hsw_lane_swap #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              swap_en,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out
);

   localparam int unsigned NBYTES = DATA_W / 8;

   if ((DATA_W % 8) != 0) begin : g_bad_width
      $error("hsw_lane_swap: DATA_W must be a whole number of bytes");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign data_out[8*b +: 8] = swap_en ? data_in[8*(NBYTES-1-b) +: 8]
                                          : data_in[8*b +: 8];
   end

endmodule

// File: rtl/hsw_beat_track.sv
module hsw_beat_track #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned CHUNK_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              chunked,
   input  logic              step,
   output logic [ADDR_W-1:0] beat_addr,
   output logic [1:0]        beat_be,
   output logic              beat_last,
   output logic              burst_sob,
   output logic [LEN_W-1:0]  burst_len
);

   localparam logic [LEN_W-1:0] TWO_L = LEN_W'(2);

   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic [LEN_W-1:0]  left_q;
   logic              chunk_q;
   logic              full_beat;
   logic [1:0]        nbytes;
   logic [LEN_W-1:0]  cur_left;

   assign full_beat = rem_q >= TWO_L;
   assign nbytes    = full_beat ? 2'd2 : 2'd1;
   assign beat_be   = full_beat ? 2'b11 : 2'b01;
   assign beat_last = rem_q <= TWO_L;
   assign beat_addr = addr_q;
   assign burst_sob = left_q == '0;

   if (CHUNK_BYTES == 0) begin : g_unchunked
      logic unused_chunk;
      assign unused_chunk = chunk_q;
      assign burst_len    = rem_q;
   end else begin : g_chunked
      localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_BYTES);
      assign burst_len = (chunk_q && rem_q > CHUNK_L) ? CHUNK_L : rem_q;
   end

   assign cur_left = burst_sob ? burst_len : left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rem_q   <= '0;
         left_q  <= '0;
         chunk_q <= 1'b0;
      end else if (load) begin
         addr_q  <= load_addr;
         rem_q   <= load_len;
         left_q  <= '0;
         chunk_q <= chunked;
      end else if (step) begin
         addr_q <= addr_q + ADDR_W'(nbytes);
         rem_q  <= rem_q - LEN_W'(nbytes);
         left_q <= cur_left - LEN_W'(nbytes);
      end
   end

endmodule

// File: rtl/hsw_dma_bridge.sv
module hsw_dma_bridge
   import hsw_dma_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned CHUNK_BYTES = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       base_addr,
   input  logic                    req_valid,
   input  logic                    req_write,
   input  logic                    req_pass,
   input  logic [ADDR_W-1:0]       req_offset,
   input  logic [LEN_W-1:0]        req_len,
   output logic                    busy,
   output logic                    done,
   input  logic                    src_valid,
   output logic                    src_ready,
   input  logic [8*BEAT_BYTES-1:0] src_data,
   output logic                    snk_valid,
   input  logic                    snk_ready,
   output logic [8*BEAT_BYTES-1:0] snk_data,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic                    mem_write,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [BEAT_BYTES-1:0]   mem_be,
   output logic [8*BEAT_BYTES-1:0] mem_wdata,
   output logic                    mem_sob,
   output logic [LEN_W-1:0]        mem_blen,
   input  logic                    mem_rvalid,
   output logic                    mem_rready,
   input  logic [8*BEAT_BYTES-1:0] mem_rdata
);

   localparam int unsigned DATA_W = 8 * BEAT_BYTES;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("hsw_dma_bridge: ADDR_W too small");
   end
   if (LEN_W < 2 || LEN_W > 31) begin : g_bad_len
      $error("hsw_dma_bridge: LEN_W out of range");
   end
   if ((CHUNK_BYTES % 2) != 0) begin : g_bad_chunk_odd
      $error("hsw_dma_bridge: CHUNK_BYTES must be even");
   end
   if (LEN_W <= 31 && CHUNK_BYTES >= (64'd1 << LEN_W)) begin : g_bad_chunk_big
      $error("hsw_dma_bridge: CHUNK_BYTES does not fit LEN_W");
   end

   xfer_state_e       state_q, state_d;
   logic              pass_q;
   logic              done_q, done_d;
   logic              accept, wr_hs, rd_hs, step, beat_last;
   logic [ADDR_W-1:0] start_addr;
   logic [LEN_W-1:0]  start_len;

   hsw_req_align #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_align (
      .base_addr (base_addr),
      .offset    (req_offset),
      .len_in    (req_len),
      .pass_mode (req_pass),
      .start_addr(start_addr),
      .start_len (start_len)
   );

   hsw_beat_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_addr(start_addr),
      .load_len (start_len),
      .chunked  (req_write && !req_pass),
      .step     (step),
      .beat_addr(mem_addr),
      .beat_be  (mem_be),
      .beat_last(beat_last),
      .burst_sob(mem_sob),
      .burst_len(mem_blen)
   );

   hsw_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
      .swap_en (!pass_q),
      .data_in (src_data),
      .data_out(mem_wdata)
   );

   hsw_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
      .swap_en (!pass_q),
      .data_in (mem_rdata),
      .data_out(snk_data)
   );

   assign accept     = req_valid && (state_q == XS_IDLE);
   assign mem_write  = state_q == XS_WRITE;
   assign mem_valid  = (mem_write && src_valid) || (state_q == XS_RD_CMD);
   assign src_ready  = mem_write && mem_ready;
   assign snk_valid  = (state_q == XS_RD_DATA) && mem_rvalid;
   assign mem_rready = (state_q == XS_RD_DATA) && snk_ready;
   assign wr_hs      = mem_write && src_valid && mem_ready;
   assign rd_hs      = (state_q == XS_RD_DATA) && mem_rvalid && snk_ready;
   assign step       = wr_hs || rd_hs;
   assign busy       = state_q != XS_IDLE;
   assign done       = done_q;

   always_comb begin
      state_d = state_q;
      done_d  = 1'b0;
      unique case (state_q)
         XS_IDLE: begin
            if (accept) begin
               if (start_len == '0) done_d  = 1'b1;
               else                 state_d = req_write ? XS_WRITE : XS_RD_CMD;
            end
         end
         XS_WRITE: begin
            if (wr_hs && beat_last) begin
               state_d = XS_IDLE;
               done_d  = 1'b1;
            end
         end
         XS_RD_CMD: begin
            if (mem_ready) state_d = XS_RD_DATA;
         end
         XS_RD_DATA: begin
            if (rd_hs) begin
               state_d = beat_last ? XS_IDLE : XS_RD_CMD;
               done_d  = beat_last;
            end
         end
         default: state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         done_q  <= 1'b0;
         pass_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         done_q  <= done_d;
         if (accept) pass_q <= req_pass;
      end
   end

endmodule

// File: rtl/hsw_dma_bridge_chk.sv
module hsw_dma_bridge_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned LEN_W       = 16,
   parameter int unsigned CHUNK_BYTES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              pass_q,
   input logic              src_ready,
   input logic [15:0]       src_data,
   input logic              snk_valid,
   input logic [15:0]       snk_data,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [1:0]        mem_be,
   input logic [15:0]       mem_wdata,
   input logic              mem_sob,
   input logic [LEN_W-1:0]  mem_blen,
   input logic [15:0]       mem_rdata
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_valid && !src_ready && !snk_valid)); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_be == 2'b11 || mem_be == 2'b01)); // R8
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> $stable(mem_addr)); // R8
   AST_SWAP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !pass_q) |-> (!mem_addr[0] && mem_be == 2'b11)); // R3
   AST_WR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && !pass_q) |-> mem_wdata == {src_data[7:0], src_data[15:8]}); // R4
   AST_RD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && !pass_q) |-> snk_data == {mem_rdata[7:0], mem_rdata[15:8]}); // R5
   AST_BURST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_write && mem_sob && !pass_q) |-> mem_blen <= LEN_W'(CHUNK_BYTES)); // R6

endmodule

bind hsw_dma_bridge hsw_dma_bridge_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass_q(pass_q),
   .src_ready(src_ready), .src_data(src_data), .snk_valid(snk_valid),
   .snk_data(snk_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
   .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
   .mem_wdata(mem_wdata), .mem_sob(mem_sob), .mem_blen(mem_blen),
   .mem_rdata(mem_rdata)
);

// File: tb/hsw_dma_bridge_test.sv
module hsw_dma_bridge_test;

   localparam int CHUNK = 64;

   typedef struct packed {
      logic [31:0] addr;
      logic [1:0]  be;
      logic        sob;
      logic [15:0] blen;
      logic        wr;
      logic        pass;
      logic        first;
      logic [15:0] wdata;
   } beat_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_addr = '0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_pass = 1'b0;
   logic [31:0] req_offset = '0;
   logic [15:0] req_len = '0;
   logic        busy, done;
   logic        src_valid = 1'b0, src_ready;
   logic [15:0] src_data = '0;
   logic        snk_valid, snk_ready = 1'b0;
   logic [15:0] snk_data;
   logic        mem_valid, mem_ready = 1'b0, mem_write;
   logic [31:0] mem_addr;
   logic [1:0]  mem_be;
   logic [15:0] mem_wdata;
   logic        mem_sob;
   logic [15:0] mem_blen;
   logic        mem_rvalid = 1'b0, mem_rready;
   logic [15:0] mem_rdata = '0;

   int    n_checks = 0, n_fail = 0, cyc = 0, last_cyc = -10, done_cnt = 0, src_idx = 0;
   beat_t exp_beats[$];
   logic [15:0] exp_rd[$];

   always #4 clk = ~clk;

   hsw_dma_bridge #(.ADDR_W(32), .LEN_W(16), .CHUNK_BYTES(CHUNK)) uut (.*);

   function automatic logic [15:0] rd_pat(input logic [31:0] a);
      return a[15:0] ^ 16'h5A3C;
   endfunction

   function automatic logic [15:0] swp(input logic [15:0] d);
      return {d[7:0], d[15:8]};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // stimulus for ready/valid patterns and the memory read model
   initial begin
      int  tick = 0;
      bit  hs_src, hs_cmd, hs_rsp;
      logic [31:0] cmd_a;
      forever begin
         @(negedge clk);
         hs_src = src_valid && src_ready;
         hs_cmd = mem_valid && mem_ready && !mem_write;
         hs_rsp = mem_rvalid && mem_rready;
         cmd_a  = mem_addr;
         @(posedge clk); #1;
         tick++;
         if (hs_src) src_idx++;
         src_data  = 16'(32'hC000 + src_idx);
         src_valid = (tick % 7) != 4;
         mem_ready = (tick % 4) != 3;
         snk_ready = (tick % 5) != 2;
         if (hs_rsp) mem_rvalid = 1'b0;
         if (hs_cmd) begin
            mem_rvalid = 1'b1;
            mem_rdata  = rd_pat(cmd_a);
         end
      end
   end

   // scoreboard monitor
   initial begin
      beat_t e;
      logic [15:0] er;
      string tg;
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst_n) continue;
         if (req_valid && !busy) last_cyc = cyc;
         if (mem_valid && mem_ready) begin
            if (exp_beats.size() == 0) begin
               chk(1'b0, "R11", "unexpected memory beat", mem_addr, 32'h0);
            end else begin
               e = exp_beats.pop_front();
               chk(mem_addr == e.addr, e.first ? "R1" : "R8", "beat address", mem_addr, e.addr);
               chk(mem_be == e.be, e.pass ? "R2" : "R3", "byte enables", {30'd0, mem_be}, {30'd0, e.be});
               chk(mem_write == e.wr, "R8", "beat direction", {31'd0, mem_write}, {31'd0, e.wr});
               tg = (e.wr && !e.pass) ? "R6" : "R7";
               if (e.sob) chk(mem_sob && mem_blen == e.blen, tg, "burst start/len",
                              {15'd0, mem_sob, mem_blen}, {15'd0, 1'b1, e.blen});
               else       chk(!mem_sob, tg, "no burst start mid-burst", {31'd0, mem_sob}, 32'h0);
               if (e.wr) chk(mem_wdata == e.wdata, e.pass ? "R2" : "R4", "write data",
                             {16'd0, mem_wdata}, {16'd0, e.wdata});
            end
            if (mem_write) last_cyc = cyc;
         end
         if (snk_valid && snk_ready) begin
            if (exp_rd.size() == 0) begin
               chk(1'b0, "R11", "unexpected read data", {16'd0, snk_data}, 32'h0);
            end else begin
               er = exp_rd.pop_front();
               chk(snk_data == er, "R5", "read data (R2 when pass-through)", {16'd0, snk_data}, {16'd0, er});
            end
            last_cyc = cyc;
         end
         if (done) begin
            done_cnt++;
            chk(cyc == last_cyc + 1, "R9", "done one cycle after last halfword", cyc, last_cyc + 1);
            chk(!busy, "R9", "busy low with done", {31'd0, busy}, 32'h0);
         end
      end
   end

   task automatic build(input bit wr, input bit pass, input logic [31:0] off, input logic [15:0] len);
      logic [31:0] a;
      logic [15:0] r, bl, blen, d;
      int k, nb;
      beat_t e;
      a = off | base_addr;
      r = len;
      if (!pass) begin a[0] = 1'b0; r[0] = 1'b0; end
      bl = 0; k = 0;
      while (r != 0) begin
         nb = (r >= 2) ? 2 : 1;
         blen = (wr && !pass && r > CHUNK) ? 16'(CHUNK) : r;
         e.sob = (bl == 0);
         if (e.sob) bl = blen;
         e.addr = a; e.be = (nb == 2) ? 2'b11 : 2'b01; e.blen = blen;
         e.wr = wr; e.pass = pass; e.first = (k == 0);
         d = 16'(32'hC000 + src_idx + k);
         e.wdata = pass ? d : swp(d);
         exp_beats.push_back(e);
         if (!wr) exp_rd.push_back(pass ? rd_pat(a) : swp(rd_pat(a)));
         bl = bl - 16'(nb); r = r - 16'(nb); a = a + 32'(nb); k++;
      end
   endtask

   task automatic issue(input bit wr, input bit pass, input logic [31:0] off, input logic [15:0] len);
      @(posedge clk); #2;
      build(wr, pass, off, len);
      req_write = wr; req_pass = pass; req_offset = off; req_len = len; req_valid = 1'b1;
      @(posedge clk); #2;
      req_valid = 1'b0;
   endtask

   task automatic wait_done(input string req);
      int d0, n;
      d0 = done_cnt - ((done === 1'b1) ? 1 : 0);
      n = 0;
      while (done_cnt <= d0 && n < 5000) begin @(negedge clk); n++; end
      chk(done_cnt > d0, req, "done reached", done_cnt, d0 + 1);
      chk(exp_beats.size() == 0 && exp_rd.size() == 0, req, "all expected beats seen",
          exp_beats.size() + exp_rd.size(), 0);
   endtask

   task automatic run(input string req, input bit wr, input bit pass,
                      input logic [31:0] off, input logic [15:0] len);
      issue(wr, pass, off, len);
      wait_done(req);
      repeat (3) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_valid, "R12", "reset outputs idle",
          {29'd0, busy, done, mem_valid}, 32'h0);
      @(posedge clk); #2; rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !mem_valid, "R12", "idle after reset release",
          {29'd0, busy, done, mem_valid}, 32'h0);

      // OR-forming: overlapping bits 0x30 | 0x12 = 0x32 (a sum would be 0x42)
      base_addr = 32'h4000_0030;
      run("R1", 1'b1, 1'b0, 32'h0000_0012, 16'd10);
      base_addr = 32'h2000_0000;
      run("R3", 1'b1, 1'b0, 32'h0000_0105, 16'd7);    // aligned to 0x104, 6 bytes
      run("R6", 1'b1, 1'b0, 32'h0000_0400, 16'd150);  // 64/64/22
      run("R2", 1'b1, 1'b1, 32'h0000_0201, 16'd5);    // odd tail, single burst
      run("R5", 1'b0, 1'b0, 32'h0000_0803, 16'd9);    // aligned 0x802, 8 bytes
      run("R2", 1'b0, 1'b1, 32'h0000_0901, 16'd3);
      run("R7", 1'b0, 1'b0, 32'h0000_1000, 16'd150);  // read is not chunked

      // zero after alignment: no beats, done in the following cycle
      d0 = done_cnt;
      run("R10", 1'b1, 1'b0, 32'h0000_0040, 16'd1);
      chk(done_cnt == d0 + 1, "R10", "single done for zero-length", done_cnt, d0 + 1);
      run("R10", 1'b0, 1'b1, 32'h0000_0050, 16'd0);

      // stray request during a transfer must be ignored
      d0 = done_cnt;
      issue(1'b1, 1'b0, 32'h0000_2000, 16'd40);
      repeat (3) @(posedge clk); #2;
      chk(busy, "R11", "busy during transfer", {31'd0, busy}, 32'h1);
      req_write = 1'b0; req_pass = 1'b1; req_offset = 32'h0000_3001; req_len = 16'd20;
      req_valid = 1'b1;
      @(posedge clk); #2;
      req_valid = 1'b0;
      wait_done("R11");
      repeat (20) @(negedge clk);
      chk(done_cnt == d0 + 1, "R11", "ignored request produced no completion", done_cnt, d0 + 1);
      chk(!busy, "R11", "idle after transfer", {31'd0, busy}, 32'h0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule